// File: doc/BRIEF.md
# Banked Video-Memory CPU Window

This block gives an 8-bit processor with a 16-bit address bus access to two large video memories through a small aperture. The aperture is a 4 KB region whose base is a parameter. Inside it, the low address bits split into a column field (X) and a row field (Y). A page register supplies the upper memory address bits. A one-bit bank register chooses which of the two memories the processor reaches. Both registers sit at their own processor addresses outside the aperture.

The memory the processor does not select always follows the raster scan-out address, which comes in as an input. Its data is presented as the pixel data. The selected memory also follows the scan address whenever the processor is not inside the aperture during the clock-high phase.

Writes to the memories never use the raw read/write level. A fast system clock counts cycles after the processor clock phase rises. A short strobe is produced a fixed number of cycles into the high phase, so the address is settled before the strobe and is still held when the strobe ends.

Top module: `vram_cpu_window`

## Requirements
- R1: After reset the page register and bank register are zero, no memory write strobe is active and the processor data output enable is low.
- R2: An access falls inside the aperture when cpu_addr[15:12] equals WIN_BASE[15:12]. Accesses outside it never write a memory and never enable the processor data output.
- R3: While phi2 is high on an aperture access, the selected memory address is {page[6:0], Y, X}, where Y is cpu_addr[11:6] and X is cpu_addr[5:0].
- R4: A write to PAGE_ADDR loads page from cpu_din[6:0], and bit 7 is dropped. A write to BANK_ADDR loads the bank from cpu_din[0]. Bank 0 selects memory 0 and bank 1 selects memory 1.
- R5: The unselected memory address always equals scan_addr. The selected memory address equals scan_addr whenever phi2 is low or the access is outside the aperture.
- R6: scan_data carries the read data of the unselected memory.
- R7: On an aperture write, the selected memory's write strobe is high for exactly STRB_LEN fast-clock cycles. It rises after the STRB_DLY-th rising clock edge that samples phi2 high. Only one memory is strobed at a time.
- R8: Reads and out-of-aperture writes produce no strobe and leave the memory contents unchanged.
- R9: cpu_doe is high only for aperture reads while phi2 is high, and cpu_dout then carries the selected memory's read data.
- R10: A write strobe is never active while phi2 is low. If phi2 falls early, the strobe stops at once.
- R11: The memory address does not change while its write strobe is held across clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | Processor clock phase, high during data transfer |
| cpu_addr | input | 16 | Processor address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_din | input | 8 | Write data from processor |
| cpu_dout | output | 8 | Read data to processor |
| cpu_doe | output | 1 | Processor data bus output enable |
| scan_addr | input | 19 | Scan-out memory address |
| scan_data | output | 8 | Pixel data from scan-side memory |
| m0_addr | output | 19 | Memory 0 address |
| m0_we | output | 1 | Memory 0 write strobe, active high |
| m0_wdata | output | 8 | Memory 0 write data |
| m0_rdata | input | 8 | Memory 0 read data |
| m1_addr | output | 19 | Memory 1 address |
| m1_we | output | 1 | Memory 1 write strobe, active high |
| m1_wdata | output | 8 | Memory 1 write data |
| m1_rdata | input | 8 | Memory 1 read data |

## Verification
The assertions run on every cycle. They check that at most one strobe is active and that no strobe starts on the edge where phi2 first reads high. They also bound each strobe's length, hold the address steady under a strobe, keep the page still without a register write, and keep the read enable and the strobe exclusive. Other behaviour is only visible through the bench scenarios: the exact start cycle of each strobe, page and bank steering, and the contents a write leaves in memory. So are read data through the aperture, the scan-side data path after bank switches, and a strobe cut short by an early fall of phi2.

// File: rtl/vram_cpu_window.sv
module vram_cpu_window #(
  parameter logic [15:0] WIN_BASE  = 16'hA000,
  parameter logic [15:0] PAGE_ADDR = 16'h9F00,
  parameter logic [15:0] BANK_ADDR = 16'h9F01,
  parameter int PAGE_W   = 7,
  parameter int FLD_W    = 6,
  parameter int DATA_W   = 8,
  parameter int STRB_DLY = 2,
  parameter int STRB_LEN = 2,
  localparam int OFS_W   = 2 * FLD_W,
  localparam int MEM_AW  = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_rw,
  input  logic [7:0]        cpu_din,
  output logic [7:0]        cpu_dout,
  output logic              cpu_doe,
  input  logic [MEM_AW-1:0] scan_addr,
  output logic [DATA_W-1:0] scan_data,
  output logic [MEM_AW-1:0] m0_addr,
  output logic              m0_we,
  output logic [DATA_W-1:0] m0_wdata,
  input  logic [DATA_W-1:0] m0_rdata,
  output logic [MEM_AW-1:0] m1_addr,
  output logic              m1_we,
  output logic [DATA_W-1:0] m1_wdata,
  input  logic [DATA_W-1:0] m1_rdata
);
  localparam int CNT_MAX = STRB_DLY + STRB_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] CNT_ON  = CNT_W'(STRB_DLY);

  logic [CNT_W-1:0]  ph_cnt;
  logic [PAGE_W-1:0] page;
  logic              bank;
  logic              in_win, cpu_own, wr_phase, strobe, reg_slot;
  logic [MEM_AW-1:0] cpu_maddr;

  assign in_win    = cpu_addr[15:OFS_W] == WIN_BASE[15:OFS_W];
  assign cpu_own   = phi2 & in_win;
  assign wr_phase  = phi2 & ~cpu_rw;
  assign strobe    = wr_phase & in_win & (ph_cnt >= CNT_ON) & (ph_cnt < CNT_TOP);
  assign reg_slot  = wr_phase & (ph_cnt == CNT_ON);
  assign cpu_maddr = {page, cpu_addr[OFS_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n)               ph_cnt <= '0;
    else if (!phi2)           ph_cnt <= '0;
    else if (ph_cnt != CNT_TOP) ph_cnt <= ph_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page <= '0;
      bank <= 1'b0;
    end else if (reg_slot) begin
      if (cpu_addr == PAGE_ADDR) page <= cpu_din[PAGE_W-1:0];
      if (cpu_addr == BANK_ADDR) bank <= cpu_din[0];
    end
  end

  assign m0_addr   = (cpu_own & ~bank) ? cpu_maddr : scan_addr;
  assign m1_addr   = (cpu_own &  bank) ? cpu_maddr : scan_addr;
  assign m0_we     = strobe & ~bank;
  assign m1_we     = strobe &  bank;
  assign m0_wdata  = cpu_din;
  assign m1_wdata  = cpu_din;
  assign cpu_doe   = cpu_own & cpu_rw;
  assign cpu_dout  = cpu_doe ? (bank ? m1_rdata : m0_rdata) : '0;
  assign scan_data = bank ? m0_rdata : m1_rdata;

  logic [CNT_W:0] we_run;
  always_ff @(posedge clk) begin
    if (!rst_n)                we_run <= '0;
    else if (m0_we || m1_we)   we_run <= we_run + 1'b1;
    else                       we_run <= '0;
  end

  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m0_we, m1_we}));

  // R7
  strobe_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi2) |-> !(m0_we || m1_we));

  // R7
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_run <= (CNT_W+1)'(STRB_LEN));

  // R11
  addr_hold0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m0_we && $past(m0_we)) |-> $stable(m0_addr));

  // R11
  addr_hold1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m1_we && $past(m1_we)) |-> $stable(m1_addr));

  // R4
  page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi2 && !cpu_rw && cpu_addr == PAGE_ADDR) |=> $stable(page));

  // R9
  doe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_doe |-> !(m0_we || m1_we));
endmodule

// File: tb/vram_cpu_window_bench.sv
module vram_cpu_window_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 2;
  localparam int LEN = 2;
  localparam int PH_LO = 3;
  localparam int PH_HI = 6;
  localparam logic [15:0] PG_A = 16'h9F00;
  localparam logic [15:0] BK_A = 16'h9F01;

  logic clk = 0, rst_n = 0, phi2 = 0, cpu_rw = 1, cpu_doe, m0_we, m1_we;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0] cpu_din = 0, cpu_dout, scan_data, m0_wdata, m1_wdata;
  logic [7:0] m0_rdata = 0, m1_rdata = 0;
  logic [18:0] scan_addr = 19'h12345, m0_addr, m1_addr;

  logic [7:0] mem0 [int];
  logic [7:0] mem1 [int];
  logic [7:0] exp_q [$];
  int n_chk = 0, n_err = 0;
  logic [6:0] page_tb = 0;
  logic bank_tb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_cpu_window u_vram_cpu_window (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_din(cpu_din), .cpu_dout(cpu_dout), .cpu_doe(cpu_doe),
    .scan_addr(scan_addr), .scan_data(scan_data),
    .m0_addr(m0_addr), .m0_we(m0_we), .m0_wdata(m0_wdata), .m0_rdata(m0_rdata),
    .m1_addr(m1_addr), .m1_we(m1_we), .m1_wdata(m1_wdata), .m1_rdata(m1_rdata));

  always @(posedge clk) begin
    if (m0_we) mem0[int'(m0_addr)] = m0_wdata;
    if (m1_we) mem1[int'(m1_addr)] = m1_wdata;
  end
  always @(clk or m0_addr) m0_rdata = mem0.exists(int'(m0_addr)) ? mem0[int'(m0_addr)] : 8'h00;
  always @(clk or m1_addr) m1_rdata = mem1.exists(int'(m1_addr)) ? mem1[int'(m1_addr)] : 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data captured during each enable window
  logic doe_q = 0;
  logic [7:0] rd_last = 0;
  always @(posedge clk) begin
    if (doe_q && !cpu_doe) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected read", int'(rd_last), 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        check(rd_last == e, "R9 read data", int'(rd_last), int'(e));
      end
    end
    if (cpu_doe) rd_last = cpu_dout;
    doe_q = cpu_doe;
  end

  task automatic bus_cycle(input logic [15:0] a, input logic rw, input logic [7:0] d);
    automatic bit inwin = (a[15:12] == 4'hA);
    automatic bit pat_ok = 1;
    automatic bit addr_ok = 1;
    @(negedge clk);
    phi2 = 0; cpu_addr = a; cpu_rw = rw; cpu_din = d;
    repeat (PH_LO - 1) @(negedge clk);
    // R5: phi2 low, both memories follow scan
    check(m0_addr == scan_addr && m1_addr == scan_addr, "R5 low phase addr",
          int'(m0_addr), int'(scan_addr));
    @(negedge clk);
    phi2 = 1;
    for (int k = 1; k <= PH_HI; k++) begin
      automatic bit s = !rw && inwin && k >= DLY && k < DLY + LEN;
      @(negedge clk);
      if (m0_we != (s && !bank_tb) || m1_we != (s && bank_tb)) pat_ok = 0;
      if (cpu_doe != (rw && inwin)) pat_ok = 0;
      if (inwin) begin
        if ((bank_tb ? m1_addr : m0_addr) != {page_tb, a[11:0]}) addr_ok = 0;
        if ((bank_tb ? m0_addr : m1_addr) != scan_addr) addr_ok = 0;
      end
    end
    // R7 R8 R2 R9: strobe and enable pattern over the high phase
    check(pat_ok, "R7 strobe/enable pattern", int'(a), int'(rw));
    // R3 R5: CPU address on selected bank, scan on the other
    check(addr_ok, "R3 window address", int'(a), int'({page_tb, a[11:0]}));
    if (!rw && a == PG_A) page_tb = d[6:0];
    if (!rw && a == BK_A) bank_tb = d[0];
    @(negedge clk);
    phi2 = 0;
  endtask

  task automatic cpu_read(input logic [15:0] a, input logic [7:0] e);
    exp_q.push_back(e);
    bus_cycle(a, 1'b1, 8'h00);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!cpu_doe && !m0_we && !m1_we, "R1 outputs idle", int'({cpu_doe, m0_we, m1_we}), 0);
    check(m0_addr == scan_addr && m1_addr == scan_addr, "R1 addresses follow scan",
          int'(m0_addr), int'(scan_addr));

    // R3 R7 write at page 0 bank 0, Y=0x3F X=0x05
    bus_cycle(16'hAFC5, 1'b0, 8'h5A);
    check(mem0.exists(19'h00FC5) && mem0[19'h00FC5] == 8'h5A, "R3 mem0 content",
          mem0.exists(19'h00FC5) ? int'(mem0[19'h00FC5]) : -1, 8'h5A);
    cpu_read(16'hAFC5, 8'h5A);

    // R4 page load drops bit 7
    bus_cycle(PG_A, 1'b0, 8'hD5);
    bus_cycle(16'hA123, 1'b0, 8'h77);
    check(mem0.exists({7'h55, 12'h123}) && mem0[{7'h55, 12'h123}] == 8'h77, "R4 page applied",
          mem0.exists({7'h55, 12'h123}) ? int'(mem0[{7'h55, 12'h123}]) : -1, 8'h77);

    // R4 bank select to memory 1
    bus_cycle(BK_A, 1'b0, 8'h01);
    bus_cycle(16'hA010, 1'b0, 8'h3C);
    check(mem1.exists({7'h55, 12'h010}) && !mem0.exists({7'h55, 12'h010}), "R4 bank 1 write",
          int'(mem1.exists({7'h55, 12'h010})), 1);
    cpu_read(16'hA010, 8'h3C);
    cpu_read(16'hA123, 8'h00);

    // R8 R2 out-of-window write and read
    bus_cycle(16'hB123, 1'b0, 8'hEE);
    check(!mem1.exists({7'h55, 12'h123}) && !mem0.exists({7'h00, 12'h123}), "R8 no write outside",
          int'(mem1.exists({7'h55, 12'h123})), 0);
    bus_cycle(16'h2010, 1'b1, 8'h00);
    // R8 read leaves memory unchanged
    check(mem1[{7'h55, 12'h010}] == 8'h3C, "R8 read keeps data", int'(mem1[{7'h55, 12'h010}]), 8'h3C);

    // R6 scan path with bank 1: scan reads memory 0
    @(negedge clk);
    scan_addr = {7'h55, 12'h123};
    @(negedge clk);
    check(scan_data == 8'h77, "R6 scan from mem0", int'(scan_data), 8'h77);
    bus_cycle(BK_A, 1'b0, 8'h00);
    @(negedge clk);
    scan_addr = {7'h55, 12'h010};
    @(negedge clk);
    check(scan_data == 8'h3C, "R6 scan from mem1", int'(scan_data), 8'h3C);
    check(m0_addr == scan_addr && m1_addr == scan_addr, "R5 idle addresses",
          int'(m1_addr), int'(scan_addr));

    // R10 phi2 falls early during strobe
    @(negedge clk);
    cpu_addr = 16'hA200; cpu_rw = 0; cpu_din = 8'h99;
    @(negedge clk);
    phi2 = 1;
    repeat (DLY) @(negedge clk);
    check(m0_we, "R10 strobe started", int'(m0_we), 1);
    phi2 = 0;
    #1;
    check(!m0_we && !m1_we, "R10 strobe cut at phi2 fall", int'(m0_we), 0);
    @(negedge clk);
    check(!m0_we && !m1_we, "R10 no strobe in low phase", int'(m0_we), 0);
    cpu_rw = 1;

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 all reads seen", exp_q.size(), 0);
    finish_run();
  end
endmodule